// File: doc/BRIEF.md
# Compression Engine Control/Status Register File

This block is the software-visible control point of a frame-based compression engine. It is a 32-bit AXI4-Lite slave that handles single-beat reads and writes and holds six word registers. It turns them into plain control ports for the datapath: an enable level, a one-cycle soft-reset pulse, the active quality setting and the restart interval. It also collects frame statistics from the datapath: a frame-done pulse together with that frame's byte count.

Quality writes are forced into the legal range 1 to 100 when they are stored. The value driven to the datapath only changes on a frame-start pulse, so one frame never mixes two quality settings. The frame-done flag is sticky and is cleared by writing a 1 to it. When a hardware event and a software clear fall in the same cycle, the hardware event wins.

Top module: `enc_csr_top`

## Requirements
- R1: After reset, every register reads as follows. Word 0x00 reads 0, word 0x04 reads 0 apart from bit 0 (the live busy input), words 0x08, 0x10 and 0x14 read 0, and word 0x0C reads 95. The outputs are enable_o=0, quality_o=95 and restart_o=0.
- R2: Bit 0 of word 0x00 is the enable bit. It is read/write and drives enable_o once the write response has been issued.
- R3: Writing 1 to bit 1 of word 0x00 produces exactly one soft_rst_o pulse, one cycle long. This bit always reads back as 0.
- R4: Bit 0 of word 0x04 shows busy_i live. Bit 1 is set by frame_done_i and cleared by writing 1 to bit 1. Writing 0 to bit 1 leaves it unchanged.
- R5: Each frame_done_i pulse adds one to word 0x08 and loads frame_bytes_i into word 0x14. Software writes to 0x08 and 0x14 have no effect.
- R6: If a frame_done_i pulse falls in the same cycle as a write-one-to-clear of bit 1 of word 0x04, the flag stays set and the count still advances.
- R7: A write to word 0x0C stores 1 if the value is 0, stores 100 if the value is above 100, and otherwise stores the value unchanged. Word 0x0C reads back the stored value.
- R8: quality_o takes the stored word 0x0C value only on a frame_start_i pulse, and holds its value at all other times.
- R9: Word 0x10 holds a 16-bit restart interval in bits 15:0 and drives restart_o. Bits 31:16 read as 0.
- R10: A write changes only the byte lanes whose wstrb_i bit is set. Bit n of the strobe covers data bits 8n+7:8n, and quality clamping is applied to the merged word.
- R11: The write address and write data may arrive in the same cycle or in either order with cycles between them. The write takes effect when the response is issued.
- R12: Reads from offsets above 0x14, or with nonzero address bits 1:0, return 0. Writes to such offsets change nothing. bresp_o and rresp_o are always 0 (OKAY).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| awaddr_i | input | ADDR_W | Write address |
| awvalid_i | input | 1 | Write address valid |
| awready_o | output | 1 | Write address ready |
| wdata_i | input | 32 | Write data |
| wstrb_i | input | 4 | Write byte strobes |
| wvalid_i | input | 1 | Write data valid |
| wready_o | output | 1 | Write data ready |
| bresp_o | output | 2 | Write response, always OKAY |
| bvalid_o | output | 1 | Write response valid |
| bready_i | input | 1 | Write response ready |
| araddr_i | input | ADDR_W | Read address |
| arvalid_i | input | 1 | Read address valid |
| arready_o | output | 1 | Read address ready |
| rdata_o | output | 32 | Read data |
| rresp_o | output | 2 | Read response, always OKAY |
| rvalid_o | output | 1 | Read data valid |
| rready_i | input | 1 | Read data ready |
| busy_i | input | 1 | Engine busy, shown live in status |
| frame_start_i | input | 1 | Frame start pulse, latches quality |
| frame_done_i | input | 1 | Frame completion pulse |
| frame_bytes_i | input | SIZE_W | Byte count of the frame completing |
| enable_o | output | 1 | Engine enable |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |
| quality_o | output | 7 | Quality applied to the current frame |
| restart_o | output | RST_W | Restart interval in MCUs, 0 disables |

## Verification
The write path is driven in three timing patterns: address and data in the same cycle, address first, and data first. This separates a correct two-channel join from one that assumes a fixed arrival order. Quality writes use 0, 1, 100, 200, an in-range value and partial-strobe merges. These tell correct clamping apart from both truncation and clamping of only the written byte. Frame-done pulses are given alone and also in the exact cycle of a status clear, which separates set-wins priority from clear-wins. Writes to the read-only counters and to unmapped or misaligned offsets, followed by read-back of every register, show that nothing else is disturbed.

// File: rtl/enc_csr_pkg.sv
package enc_csr_pkg;
  localparam int DATA_W   = 32;
  localparam int STRB_W   = DATA_W / 8;
  localparam int NUM_REGS = 6;
  localparam int QUAL_W   = 7;
  localparam int QUAL_MIN = 1;
  localparam int QUAL_MAX = 100;
  localparam int QUAL_RST = 95;

  // word index = byte offset / 4
  localparam int IDX_CTRL  = 0;
  localparam int IDX_STAT  = 1;
  localparam int IDX_FCNT  = 2;
  localparam int IDX_QUAL  = 3;
  localparam int IDX_RSTI  = 4;
  localparam int IDX_FSIZE = 5;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [STRB_W-1:0] strb_t;

  function automatic word_t lane_merge(word_t old_v, word_t new_v, strb_t strb);
    word_t r;
    r = old_v;
    for (int i = 0; i < STRB_W; i++) begin
      if (strb[i]) r[8*i +: 8] = new_v[8*i +: 8];
    end
    return r;
  endfunction

  function automatic logic [QUAL_W-1:0] clamp_quality(word_t v);
    if (v < word_t'(QUAL_MIN)) return QUAL_W'(QUAL_MIN);
    if (v > word_t'(QUAL_MAX)) return QUAL_W'(QUAL_MAX);
    return v[QUAL_W-1:0];
  endfunction
endpackage

// File: rtl/enc_csr_axil_if.sv
module enc_csr_axil_if
  import enc_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  word_t             wdata_i,
  input  strb_t             wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output word_t             rdata_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  input  word_t             rd_word_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output word_t             wr_data_o,
  output strb_t             wr_strb_o
);
  logic              aw_full_q, w_full_q, bvalid_q, rvalid_q;
  logic [ADDR_W-1:0] aw_addr_q;
  word_t             w_data_q, rdata_q;
  strb_t             w_strb_q;
  logic              wr_fire;

  assign awready_o = !aw_full_q;
  assign wready_o  = !w_full_q;
  assign arready_o = !rvalid_q;
  // commit once both halves are held and the previous response is gone
  assign wr_fire   = aw_full_q && w_full_q && !bvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_full_q <= 1'b0;
      aw_addr_q <= '0;
    end else if (awvalid_i && !aw_full_q) begin
      aw_full_q <= 1'b1;
      aw_addr_q <= awaddr_i;
    end else if (wr_fire) begin
      aw_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_full_q <= 1'b0;
      w_data_q <= '0;
      w_strb_q <= '0;
    end else if (wvalid_i && !w_full_q) begin
      w_full_q <= 1'b1;
      w_data_q <= wdata_i;
      w_strb_q <= wstrb_i;
    end else if (wr_fire) begin
      w_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bvalid_q <= 1'b0;
    else if (wr_fire)  bvalid_q <= 1'b1;
    else if (bready_i) bvalid_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (arvalid_i && !rvalid_q) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_word_i;
    end else if (rready_i) begin
      rvalid_q <= 1'b0;
    end
  end

  assign bvalid_o  = bvalid_q;
  assign rvalid_o  = rvalid_q;
  assign rdata_o   = rdata_q;
  assign wr_en_o   = wr_fire;
  assign wr_addr_o = aw_addr_q;
  assign wr_data_o = w_data_q;
  assign wr_strb_o = w_strb_q;
endmodule

// File: rtl/enc_csr_regfile.sv
module enc_csr_regfile
  import enc_csr_pkg::*;
#(
  parameter int RST_W  = 16,
  parameter int CNT_W  = 32,
  parameter int SIZE_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REGS-1:0] wr_sel_i,
  input  word_t               wr_data_i,
  input  strb_t               wr_strb_i,
  input  logic                frame_start_i,
  input  logic                frame_done_i,
  input  logic [SIZE_W-1:0]   frame_bytes_i,
  output logic                enable_o,
  output logic                soft_rst_o,
  output logic [QUAL_W-1:0]   quality_reg_o,
  output logic [QUAL_W-1:0]   quality_act_o,
  output logic [RST_W-1:0]    restart_o,
  output logic                done_flag_o,
  output logic [CNT_W-1:0]    frame_cnt_o,
  output logic [SIZE_W-1:0]   frame_size_o
);
  logic                enable_q, soft_q, done_q;
  logic [QUAL_W-1:0]   qual_q, qual_act_q;
  logic [RST_W-1:0]    restart_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [SIZE_W-1:0]   size_q;
  logic                ctrl_lane0;

  assign ctrl_lane0 = wr_sel_i[IDX_CTRL] && wr_strb_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= 1'b0;
      soft_q   <= 1'b0;
    end else begin
      if (ctrl_lane0) enable_q <= wr_data_i[0];
      soft_q <= ctrl_lane0 && wr_data_i[1];
    end
  end

  // hardware set has priority over software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      done_q <= 1'b0;
    else if (frame_done_i)
      done_q <= 1'b1;
    else if (wr_sel_i[IDX_STAT] && wr_strb_i[0] && wr_data_i[1])
      done_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      size_q <= '0;
    end else if (frame_done_i) begin
      cnt_q  <= cnt_q + 1'b1;
      size_q <= frame_bytes_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      qual_q <= QUAL_W'(QUAL_RST);
    else if (wr_sel_i[IDX_QUAL])
      qual_q <= clamp_quality(lane_merge(word_t'(qual_q), wr_data_i, wr_strb_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            qual_act_q <= QUAL_W'(QUAL_RST);
    else if (frame_start_i) qual_act_q <= qual_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      restart_q <= '0;
    else if (wr_sel_i[IDX_RSTI])
      restart_q <= RST_W'(lane_merge(word_t'(restart_q), wr_data_i, wr_strb_i));
  end

  assign enable_o      = enable_q;
  assign soft_rst_o    = soft_q;
  assign quality_reg_o = qual_q;
  assign quality_act_o = qual_act_q;
  assign restart_o     = restart_q;
  assign done_flag_o   = done_q;
  assign frame_cnt_o   = cnt_q;
  assign frame_size_o  = size_q;
endmodule

// File: rtl/enc_csr_top.sv
module enc_csr_top
  import enc_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int RST_W  = 16,
  parameter int CNT_W  = 32,
  parameter int SIZE_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [31:0]       rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  input  logic              busy_i,
  input  logic              frame_start_i,
  input  logic              frame_done_i,
  input  logic [SIZE_W-1:0] frame_bytes_i,
  output logic              enable_o,
  output logic              soft_rst_o,
  output logic [6:0]        quality_o,
  output logic [RST_W-1:0]  restart_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic                wr_en;
  logic [ADDR_W-1:0]   wr_addr;
  word_t               wr_data, rd_word;
  strb_t               wr_strb;
  logic [NUM_REGS-1:0] wr_sel;
  logic                wr_aligned, rd_aligned;
  logic [IDX_W-1:0]    wr_idx, rd_idx;
  logic                enable, done_flag;
  logic [QUAL_W-1:0]   quality_reg;
  logic [RST_W-1:0]    restart;
  logic [CNT_W-1:0]    frame_cnt;
  logic [SIZE_W-1:0]   frame_size;

  enc_csr_axil_if #(.ADDR_W(ADDR_W)) axil_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .awaddr_i  (awaddr_i),
    .awvalid_i (awvalid_i),
    .awready_o (awready_o),
    .wdata_i   (wdata_i),
    .wstrb_i   (wstrb_i),
    .wvalid_i  (wvalid_i),
    .wready_o  (wready_o),
    .bvalid_o  (bvalid_o),
    .bready_i  (bready_i),
    .arvalid_i (arvalid_i),
    .arready_o (arready_o),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o),
    .rready_i  (rready_i),
    .rd_word_i (rd_word),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .wr_strb_o (wr_strb)
  );

  assign wr_idx     = wr_addr[ADDR_W-1:2];
  assign wr_aligned = (wr_addr[1:0] == 2'b00);
  assign rd_idx     = araddr_i[ADDR_W-1:2];
  assign rd_aligned = (araddr_i[1:0] == 2'b00);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_wr_sel
    assign wr_sel[g] = wr_en && wr_aligned && (wr_idx == IDX_W'(g));
  end

  enc_csr_regfile #(.RST_W(RST_W), .CNT_W(CNT_W), .SIZE_W(SIZE_W)) regs_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_sel_i      (wr_sel),
    .wr_data_i     (wr_data),
    .wr_strb_i     (wr_strb),
    .frame_start_i (frame_start_i),
    .frame_done_i  (frame_done_i),
    .frame_bytes_i (frame_bytes_i),
    .enable_o      (enable),
    .soft_rst_o    (soft_rst_o),
    .quality_reg_o (quality_reg),
    .quality_act_o (quality_o),
    .restart_o     (restart),
    .done_flag_o   (done_flag),
    .frame_cnt_o   (frame_cnt),
    .frame_size_o  (frame_size)
  );

  always_comb begin
    rd_word = '0;
    if (rd_aligned) begin
      case (rd_idx)
        IDX_W'(IDX_CTRL):  rd_word = {31'b0, enable};
        IDX_W'(IDX_STAT):  rd_word = {30'b0, done_flag, busy_i};
        IDX_W'(IDX_FCNT):  rd_word = word_t'(frame_cnt);
        IDX_W'(IDX_QUAL):  rd_word = word_t'(quality_reg);
        IDX_W'(IDX_RSTI):  rd_word = word_t'(restart);
        IDX_W'(IDX_FSIZE): rd_word = word_t'(frame_size);
        default:           rd_word = '0;
      endcase
    end
  end

  assign enable_o  = enable;
  assign restart_o = restart;
  assign bresp_o   = 2'b00;
  assign rresp_o   = 2'b00;
endmodule

// File: rtl/enc_csr_chk.sv
module enc_csr_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             soft_rst_i,
  input logic             frame_start_i,
  input logic             frame_done_i,
  input logic             done_flag_i,
  input logic [CNT_W-1:0] frame_cnt_i,
  input logic [6:0]       quality_i,
  input logic             bvalid_i,
  input logic             bready_i,
  input logic [1:0]       bresp_i,
  input logic             rvalid_i,
  input logic [1:0]       rresp_i
);
  assert_pulse_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !soft_rst_i);

  assert_done_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_i |=> done_flag_i);

  assert_cnt_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_i |=> frame_cnt_i == $past(frame_cnt_i) + {{(CNT_W-1){1'b0}}, 1'b1});

  assert_cnt_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_done_i |=> $stable(frame_cnt_i));

  assert_quality_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quality_i >= 7'd1 && quality_i <= 7'd100);

  assert_quality_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(quality_i));

  assert_bvalid_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_i && !bready_i |=> bvalid_i);

  assert_bresp_okay_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_i |-> bresp_i == 2'b00);

  assert_rresp_okay_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_i |-> rresp_i == 2'b00);
endmodule

bind enc_csr_top enc_csr_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .soft_rst_i    (soft_rst_o),
  .frame_start_i (frame_start_i),
  .frame_done_i  (frame_done_i),
  .done_flag_i   (done_flag),
  .frame_cnt_i   (frame_cnt),
  .quality_i     (quality_o),
  .bvalid_i      (bvalid_o),
  .bready_i      (bready_i),
  .bresp_i       (bresp_o),
  .rvalid_i      (rvalid_o),
  .rresp_i       (rresp_o)
);

// File: tb/enc_csr_top_tb_top.sv
module enc_csr_top_tb_top;
  localparam int CLK_P = 20;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  awaddr_i = '0, araddr_i = '0;
  logic        awvalid_i = 0, wvalid_i = 0, arvalid_i = 0;
  logic        bready_i = 1, rready_i = 1;
  logic [31:0] wdata_i = '0;
  logic [3:0]  wstrb_i = '0;
  logic        busy_i = 0, frame_start_i = 0, frame_done_i = 0;
  logic [31:0] frame_bytes_i = '0;
  logic        awready_o, wready_o, bvalid_o, arready_o, rvalid_o;
  logic [1:0]  bresp_o, rresp_o;
  logic [31:0] rdata_o;
  logic        enable_o, soft_rst_o;
  logic [6:0]  quality_o;
  logic [15:0] restart_o;

  always #(CLK_P/2) clk_i = ~clk_i;

  enc_csr_top dut_i (.*);

  int nvec = 0, nfail = 0;
  int pulse_cnt = 0, m_pulses = 0;
  logic        mon_on = 0;
  logic        m_en = 0, m_done = 0;
  logic [31:0] m_cnt = 0, m_size = 0, m_q = 95, m_rst = 0;
  logic [6:0]  m_qact = 95;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    #1;
    if (mon_on) begin
      if (soft_rst_o) pulse_cnt++;
      nvec++;
      if (enable_o !== m_en || quality_o !== m_qact || restart_o !== m_rst[15:0]) begin
        nfail++;
        $display("FAIL R2/R8/R9 outputs actual=%b/%0d/%h expected=%b/%0d/%h",
                 enable_o, quality_o, restart_o, m_en, m_qact, m_rst[15:0]);
      end
    end
  end

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] s);
    logic [31:0] r = o;
    for (int i = 0; i < 4; i++) if (s[i]) r[8*i +: 8] = n[8*i +: 8];
    return r;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    logic [31:0] v;
    if (a[1:0] != 0) return;
    case (a[7:2])
      0: if (s[0]) begin m_en = d[0]; if (d[1]) m_pulses++; end
      1: if (s[0] && d[1]) m_done = 0;
      3: begin
           v = merge(m_q, d, s);
           m_q = (v == 0) ? 1 : (v > 100) ? 100 : v;
         end
      4: begin v = merge(m_rst, d, s); m_rst = {16'b0, v[15:0]}; end
      default: ;
    endcase
  endtask

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    if (a[1:0] != 0) return 0;
    case (a[7:2])
      0: return {31'b0, m_en};
      1: return {30'b0, m_done, busy_i};
      2: return m_cnt;
      3: return m_q;
      4: return m_rst;
      5: return m_size;
      default: return 0;
    endcase
  endfunction

  // order: 0 same cycle, 1 address first, 2 data first
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s, input int order);
    @(negedge clk_i);
    if (order != 2) begin awaddr_i = a; awvalid_i = 1; end
    if (order != 1) begin wdata_i = d; wstrb_i = s; wvalid_i = 1; end
    @(negedge clk_i);
    awvalid_i = 0; wvalid_i = 0;
    if (order != 0) begin
      repeat (2) @(negedge clk_i);
      if (order == 1) begin wdata_i = d; wstrb_i = s; wvalid_i = 1; end
      else begin awaddr_i = a; awvalid_i = 1; end
      @(negedge clk_i);
      awvalid_i = 0; wvalid_i = 0;
    end
    while (!bvalid_o) @(negedge clk_i);
    if (bresp_o !== 2'b00) check("R12 bresp", {30'b0, bresp_o}, 0);
    model_write(a, d, s);
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    logic [31:0] d;
    @(negedge clk_i);
    araddr_i = a; arvalid_i = 1;
    @(negedge clk_i);
    while (!rvalid_o) @(negedge clk_i);
    arvalid_i = 0;
    d = rdata_o;
    if (rresp_o !== 2'b00) check("R12 rresp", {30'b0, rresp_o}, 0);
    check(tag, d, exp_rd(a));
  endtask

  task automatic pulse_done(input logic [31:0] bytes);
    @(negedge clk_i);
    frame_done_i = 1; frame_bytes_i = bytes;
    @(negedge clk_i);
    frame_done_i = 0;
    m_cnt++; m_size = bytes; m_done = 1;
  endtask

  task automatic pulse_start();
    @(negedge clk_i);
    frame_start_i = 1;
    @(negedge clk_i);
    frame_start_i = 0;
    m_qact = m_q[6:0];
  endtask

  task automatic rd_all(input string tag);
    for (int i = 0; i < 6; i++) rd_chk(8'(4*i), tag);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    mon_on = 1;
    // R1 reset state
    check("R1 quality_o", {25'b0, quality_o}, 95);
    rd_all("R1 reset value");

    // R2, R11 same-cycle
    wr(8'h00, 32'h1, 4'hF, 0);
    rd_chk(8'h00, "R2 enable readback");
    // R3 soft reset pulse
    wr(8'h00, 32'h3, 4'hF, 0);
    repeat (3) @(negedge clk_i);
    check("R3 pulse count", pulse_cnt, m_pulses);
    rd_chk(8'h00, "R3 bit1 reads 0");
    // R10 no strobes
    wr(8'h00, 32'h0, 4'h0, 0);
    rd_chk(8'h00, "R10 no-strobe ctrl");

    // R4 busy live, done flag
    busy_i = 1;
    rd_chk(8'h04, "R4 busy live");
    pulse_done(32'd1234);
    rd_chk(8'h04, "R4 done set");
    rd_chk(8'h08, "R5 count");
    rd_chk(8'h14, "R5 size");
    wr(8'h04, 32'h0, 4'hF, 0);
    rd_chk(8'h04, "R4 write 0 no effect");
    wr(8'h04, 32'h2, 4'hF, 0);
    rd_chk(8'h04, "R4 W1C");
    busy_i = 0;
    // R5 read-only
    wr(8'h08, 32'h55, 4'hF, 0);
    wr(8'h14, 32'hAA, 4'hF, 0);
    rd_chk(8'h08, "R5 count write ignored");
    rd_chk(8'h14, "R5 size write ignored");

    // R6 coincident done and clear
    pulse_done(32'd500);
    @(negedge clk_i);
    awaddr_i = 8'h04; awvalid_i = 1; wdata_i = 32'h2; wstrb_i = 4'hF; wvalid_i = 1;
    @(negedge clk_i);
    awvalid_i = 0; wvalid_i = 0;
    frame_done_i = 1; frame_bytes_i = 32'd777;
    @(negedge clk_i);
    frame_done_i = 0;
    check("R6 bvalid at coincidence", {31'b0, bvalid_o}, 1);
    m_cnt++; m_size = 32'd777; m_done = 1;
    rd_chk(8'h04, "R6 set wins");
    rd_chk(8'h08, "R6 count");
    rd_chk(8'h14, "R6 size");

    // R7, R8 quality
    wr(8'h0C, 32'd50, 4'hF, 0);
    rd_chk(8'h0C, "R7 in range");
    check("R8 quality held", {25'b0, quality_o}, 95);
    pulse_start();
    check("R8 quality on start", {25'b0, quality_o}, 50);
    wr(8'h0C, 32'd0, 4'hF, 0);
    rd_chk(8'h0C, "R7 zero to 1");
    wr(8'h0C, 32'd200, 4'hF, 0);
    rd_chk(8'h0C, "R7 200 to 100");
    wr(8'h0C, 32'd1, 4'hF, 0);
    rd_chk(8'h0C, "R7 min");
    wr(8'h0C, 32'd100, 4'hF, 0);
    rd_chk(8'h0C, "R7 max");
    wr(8'h0C, 32'h0001_0000, 4'hF, 0);
    rd_chk(8'h0C, "R7 upper bits clamp");
    pulse_start();
    wr(8'h0C, 32'h0000_0A50, 4'h1, 0);
    rd_chk(8'h0C, "R10 lane0 only");
    wr(8'h0C, 32'h0000_0500, 4'h2, 0);
    rd_chk(8'h0C, "R10 lane1 merge clamp");

    // R9 restart
    wr(8'h10, 32'hDEAD_BEEF, 4'hF, 0);
    rd_chk(8'h10, "R9 width");
    wr(8'h10, 32'h00FF_0000, 4'h4, 0);
    rd_chk(8'h10, "R10 upper lane");
    wr(8'h10, 32'h0000_1234, 4'hF, 1);
    rd_chk(8'h10, "R11 aw first");
    wr(8'h10, 32'h0000_0042, 4'h3, 2);
    rd_chk(8'h10, "R11 w first");
    wr(8'h00, 32'h0, 4'h1, 2);
    rd_chk(8'h00, "R11 ctrl w first");

    // R12 unmapped and misaligned
    wr(8'h18, 32'hFFFF_FFFF, 4'hF, 0);
    wr(8'h3C, 32'hFFFF_FFFF, 4'hF, 1);
    wr(8'h0E, 32'd7, 4'hF, 0);
    wr(8'h01, 32'h1, 4'hF, 0);
    rd_chk(8'h18, "R12 unmapped read");
    rd_chk(8'h1C, "R12 unmapped read");
    rd_chk(8'h0D, "R12 misaligned read");
    rd_all("R12 no side effect");

    repeat (4) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    nfail++;
    $display("FAIL R11 watchdog actual=hung expected=complete");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule